// File: doc/BRIEF.md
# Utilisation-Driven Clock/Voltage Step Controller

This controller picks one of six operating points for a processor core. Each point pairs a clock ratio with a supply voltage. The ladder runs from a fixed slowest point, used at reset, up to the core's full-speed point. The controller counts the busy cycles reported on `busy_i` over a window whose length software programs. At the end of each window it compares that count with two separate thresholds. It then climbs one rung, drops one rung, or holds.

A move is always made as a clock/voltage pair, and the order is fixed so that the core is never clocked faster than its supply allows:

- **Climbing:** the higher voltage code is presented first. The controller then waits for the regulator to report ready, and only then changes the clock ratio.
- **Descending:** the clock ratio is lowered first. The lower voltage code follows one cycle later, and the controller waits for ready before the step counts as done.

The PLL, the regulator and the analogue side are outside this block.

Top module: `dvfs_step_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are:
  - `op_idx_o` = 0
  - `vcode_o` = 956
  - `clk_ratio_o` = 6
  - `vreq_o` = 0
- R2: Operating point k (0..5) pairs the following values, and both outputs hold the pair of `op_idx_o` in the cycle that `op_idx_o` takes a new value:
  - clock ratio code {6, 8, 10, 12, 14, 16} (multiples of a 100 MHz reference)
  - voltage code in millivolts {956, 1036, 1164, 1276, 1420, 1484}
- R3: A window lasts `win_len_i` cycles, with 0 treated as 1. The busy count is the number of cycles in the window with `busy_i` high. While the step requests are serviced at once, an upward step completes every `win_len_i` cycles.
- R4: When the window count is strictly greater than `thr_up_i` and the index is below 5, the controller starts a step up by one. An equal count does not step up.
- R5: When the window count is strictly less than `thr_dn_i`, the index is above 0 and R4 does not apply, the controller starts a step down by one.
- R6: A count that is neither above `thr_up_i` nor below `thr_dn_i` leaves the operating point unchanged.
- R7: The index never leaves 0..5. Demand at the top point holds the index at 5, and idleness at the bottom point holds it at 0.
- R8: On a step up, the sequence is:
  - At the window-end edge, `vcode_o` takes the new point's value and `vreq_o` rises, while `clk_ratio_o` and `op_idx_o` keep their old values.
  - `clk_ratio_o` and `op_idx_o` update on the first edge at which `vreq_o` and `vreg_ready_i` are both high.
  - `vreq_o` then falls.
- R9: On a step down, the sequence is:
  - `clk_ratio_o` drops at the window-end edge while `vcode_o` is unchanged.
  - `vcode_o` drops on the next edge and `vreq_o` rises.
  - `op_idx_o` updates on the first edge at which `vreq_o` and `vreg_ready_i` are both high.
- R10: The index changes by at most one per step. A window that ends while a step is in progress is discarded, so a long regulator wait still yields a single step.
- R11: While `vreq_o` is high and `vreg_ready_i` is low, `vcode_o` and `clk_ratio_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | High in each cycle the core is busy |
| win_len_i | input | WIN_W | Window length in cycles (0 acts as 1) |
| thr_up_i | input | WIN_W | Count above which the controller climbs |
| thr_dn_i | input | WIN_W | Count below which the controller descends |
| vreg_ready_i | input | 1 | Regulator has settled at the requested code |
| op_idx_o | output | 3 | Current operating-point index, 0 = slowest |
| vcode_o | output | 11 | Requested supply voltage in millivolts |
| clk_ratio_o | output | 5 | Requested clock ratio code |
| vreq_o | output | 1 | Voltage change pending, waiting for regulator ready |

## Verification
The checker watches the following on every cycle:
- the clock never rises unless the voltage is already settled and ready has been seen;
- the voltage never falls in the same cycle as the clock, and the clock never falls in the same cycle as the voltage;
- the outputs stay frozen while the regulator is not ready;
- the index moves by at most one;
- the outputs form a table pair whenever the index moves.

Only the bench scenarios can show the following:
- that the threshold comparisons are strict at the boundary count;
- that hysteresis holds a count lying between the thresholds;
- that the window length sets the step period;
- that windows ending during a long regulator wait are discarded;
- that the ladder saturates at both ends.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  localparam int NUM_OP = 6;
  localparam int IDX_W  = 3;
  localparam int VC_W   = 11;
  localparam int RC_W   = 5;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_OP - 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UP_V  = 2'd1,
    ST_DN_C  = 2'd2,
    ST_DN_V  = 2'd3
  } seq_state_t;

  // Supply level in millivolts for each rung of the ladder.
  function automatic logic [VC_W-1:0] op_vcode(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    op_vcode = 11'd956;
      3'd1:    op_vcode = 11'd1036;
      3'd2:    op_vcode = 11'd1164;
      3'd3:    op_vcode = 11'd1276;
      3'd4:    op_vcode = 11'd1420;
      default: op_vcode = 11'd1484;
    endcase
  endfunction

  // Clock multiplier over a 100 MHz reference: 6, 8, ... 16.
  function automatic logic [RC_W-1:0] op_ratio(input logic [IDX_W-1:0] idx);
    op_ratio = RC_W'(6) + RC_W'({idx, 1'b0});
  endfunction

endpackage

// File: rtl/dvfs_util_window.sv
module dvfs_util_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             win_end_o,
  output logic [WIN_W-1:0] win_count_o
);

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0] acc_q, acc_d;
  logic [WIN_W:0]   cnt_inc;
  logic [WIN_W-1:0] sum;
  logic             last;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{WIN_W{1'b0}}, 1'b1};
    last    = (cnt_inc >= {1'b0, win_len_i});
    sum     = acc_q + {{(WIN_W-1){1'b0}}, busy_i};
    if (last) begin
      cnt_d = '0;
      acc_d = '0;
    end else begin
      cnt_d = cnt_inc[WIN_W-1:0];
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign win_end_o   = last;
  assign win_count_o = sum;

endmodule

// File: rtl/dvfs_step_decide.sv
module dvfs_step_decide
  import dvfs_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             win_end_i,
  input  logic [WIN_W-1:0] count_i,
  input  logic [WIN_W-1:0] thr_up_i,
  input  logic [WIN_W-1:0] thr_dn_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  output logic             step_up_o,
  output logic             step_dn_o
);

  logic over, under;

  always_comb begin
    over      = (count_i > thr_up_i);
    under     = (count_i < thr_dn_i);
    // Demand wins if thresholds are programmed to overlap.
    step_up_o = win_end_i && over && (cur_idx_i != TOP_IDX);
    step_dn_o = win_end_i && !over && under && (cur_idx_i != '0);
  end

endmodule

// File: rtl/dvfs_seq_fsm.sv
module dvfs_seq_fsm
  import dvfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             vreg_ready_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic [VC_W-1:0]  vcode_o,
  output logic [RC_W-1:0]  ratio_o,
  output logic             vreq_o
);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] tgt_q, tgt_d;
  logic [VC_W-1:0]  vcode_q, vcode_d;
  logic [RC_W-1:0]  ratio_q, ratio_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    tgt_d   = tgt_q;
    vcode_d = vcode_q;
    ratio_d = ratio_q;
    case (state_q)
      ST_IDLE: begin
        // Window ends arriving in other states are dropped.
        if (step_up_i) begin
          tgt_d   = cur_q + 1'b1;
          vcode_d = op_vcode(cur_q + 1'b1);
          state_d = ST_UP_V;
        end else if (step_dn_i) begin
          tgt_d   = cur_q - 1'b1;
          ratio_d = op_ratio(cur_q - 1'b1);
          state_d = ST_DN_C;
        end
      end
      ST_UP_V: begin
        if (vreg_ready_i) begin
          ratio_d = op_ratio(tgt_q);
          cur_d   = tgt_q;
          state_d = ST_IDLE;
        end
      end
      ST_DN_C: begin
        vcode_d = op_vcode(tgt_q);
        state_d = ST_DN_V;
      end
      ST_DN_V: begin
        if (vreg_ready_i) begin
          cur_d   = tgt_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      tgt_q   <= '0;
      vcode_q <= op_vcode('0);
      ratio_q <= op_ratio('0);
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      vcode_q <= vcode_d;
      ratio_q <= ratio_d;
    end
  end

  assign cur_idx_o = cur_q;
  assign vcode_o   = vcode_q;
  assign ratio_o   = ratio_q;
  assign vreq_o    = (state_q == ST_UP_V) || (state_q == ST_DN_V);

endmodule

// File: rtl/dvfs_step_ctrl.sv
module dvfs_step_ctrl
  import dvfs_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [WIN_W-1:0] thr_up_i,
  input  logic [WIN_W-1:0] thr_dn_i,
  input  logic             vreg_ready_i,
  output logic [IDX_W-1:0] op_idx_o,
  output logic [VC_W-1:0]  vcode_o,
  output logic [RC_W-1:0]  clk_ratio_o,
  output logic             vreq_o
);

  logic             win_end;
  logic [WIN_W-1:0] win_count;
  logic             step_up, step_dn;
  logic [IDX_W-1:0] cur_idx;

  dvfs_util_window #(.WIN_W(WIN_W)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .win_len_i   (win_len_i),
    .win_end_o   (win_end),
    .win_count_o (win_count)
  );

  dvfs_step_decide #(.WIN_W(WIN_W)) u_decide (
    .win_end_i (win_end),
    .count_i   (win_count),
    .thr_up_i  (thr_up_i),
    .thr_dn_i  (thr_dn_i),
    .cur_idx_i (cur_idx),
    .step_up_o (step_up),
    .step_dn_o (step_dn)
  );

  dvfs_seq_fsm u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_up_i    (step_up),
    .step_dn_i    (step_dn),
    .vreg_ready_i (vreg_ready_i),
    .cur_idx_o    (cur_idx),
    .vcode_o      (vcode_o),
    .ratio_o      (clk_ratio_o),
    .vreq_o       (vreq_o)
  );

  assign op_idx_o = cur_idx;

endmodule

// File: rtl/dvfs_step_ctrl_chk.sv
module dvfs_step_ctrl_chk
  import dvfs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             vreg_ready_i,
  input logic             vreq_o,
  input logic [IDX_W-1:0] op_idx_o,
  input logic [VC_W-1:0]  vcode_o,
  input logic [RC_W-1:0]  clk_ratio_o
);

  // R2: a newly reached point presents its full pair
  a_r2_pair_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    (op_idx_o != $past(op_idx_o)) |->
      (vcode_o == op_vcode(op_idx_o) && clk_ratio_o == op_ratio(op_idx_o)));

  // R8: clock only rises after the voltage was held and ready was seen
  a_r8_clk_up_after_v: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ratio_o > $past(clk_ratio_o)) |->
      (vcode_o == $past(vcode_o) && $past(vreq_o) && $past(vreg_ready_i)));

  // R9: clock drop does not coincide with a voltage change
  a_r9_clk_dn_first: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ratio_o < $past(clk_ratio_o)) |-> (vcode_o == $past(vcode_o)));

  // R9: voltage drop only after the clock has already dropped
  a_r9_v_dn_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode_o < $past(vcode_o)) |->
      (clk_ratio_o == $past(clk_ratio_o) && clk_ratio_o == op_ratio(op_idx_o - 1'b1)));

  // R10: one rung at a time
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_idx_o == $past(op_idx_o)) || (op_idx_o == $past(op_idx_o) + 1'b1) ||
    (op_idx_o + 1'b1 == $past(op_idx_o)));

  // R11: outputs frozen while the regulator is not ready
  a_r11_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (vreq_o && !vreg_ready_i) |=> ($stable(vcode_o) && $stable(clk_ratio_o)));

  // R7: index stays on the ladder
  always @(posedge clk) begin
    if (rst_n) begin
      a_r7_range: assert (op_idx_o <= TOP_IDX);
    end
  end

endmodule

bind dvfs_step_ctrl dvfs_step_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vreg_ready_i (vreg_ready_i),
  .vreq_o       (vreq_o),
  .op_idx_o     (op_idx_o),
  .vcode_o      (vcode_o),
  .clk_ratio_o  (clk_ratio_o)
);

// File: tb/dvfs_step_ctrl_tb.sv
module dvfs_step_ctrl_tb;

  localparam int WIN_W = 16;

  logic             clk;
  logic             rst_n;
  logic             busy_lvl, alt_en, alt_bit;
  logic             busy_i;
  logic [WIN_W-1:0] win_len_i, thr_up_i, thr_dn_i;
  logic             vreg_ready_i;
  logic [2:0]       op_idx_o;
  logic [10:0]      vcode_o;
  logic [4:0]       clk_ratio_o;
  logic             vreq_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_v [6] = '{956, 1036, 1164, 1276, 1420, 1484};
  int exp_r [6] = '{6, 8, 10, 12, 14, 16};

  assign busy_i = alt_en ? alt_bit : busy_lvl;

  dvfs_step_ctrl #(.WIN_W(WIN_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .win_len_i    (win_len_i),
    .thr_up_i     (thr_up_i),
    .thr_dn_i     (thr_dn_i),
    .vreg_ready_i (vreg_ready_i),
    .op_idx_o     (op_idx_o),
    .vcode_o      (vcode_o),
    .clk_ratio_o  (clk_ratio_o),
    .vreq_o       (vreq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) alt_bit <= alt_en ? ~alt_bit : 1'b0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idx(input int idx, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (op_idx_o == idx) break;
    end
  endtask

  task automatic t_reset;
    check("R1 idx", op_idx_o, 0);
    check("R1 vcode", vcode_o, 956);
    check("R1 ratio", clk_ratio_o, 6);
    check("R1 vreq", vreq_o, 0);
  endtask

  task automatic t_bottom_sat;
    vreg_ready_i = 1; busy_lvl = 0; thr_dn_i = 3; thr_up_i = 8;
    wait_cyc(45);
    check("R7 bottom idx", op_idx_o, 0);
    check("R7 bottom ratio", clk_ratio_o, 6);
  endtask

  task automatic t_hysteresis;
    alt_en = 1; thr_up_i = 5; thr_dn_i = 5;
    wait_cyc(50);
    check("R6 hold at boundary", op_idx_o, 0);
    thr_up_i = 4;
    wait_idx(1, 40);
    check("R4 step up", op_idx_o, 1);
    check("R2 pair vcode", vcode_o, exp_v[1]);
    check("R2 pair ratio", clk_ratio_o, exp_r[1]);
    thr_up_i = 15; thr_dn_i = 0;
    alt_en = 0;
  endtask

  task automatic t_up_order;
    vreg_ready_i = 0; busy_lvl = 1; thr_up_i = 5;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (vreq_o) break;
    end
    check("R8 vreq up", vreq_o, 1);
    check("R8 vcode first", vcode_o, exp_v[2]);
    check("R8 ratio old", clk_ratio_o, exp_r[1]);
    check("R8 idx old", op_idx_o, 1);
    wait_cyc(25);
    check("R11 vcode held", vcode_o, exp_v[2]);
    check("R11 ratio held", clk_ratio_o, exp_r[1]);
    vreg_ready_i = 1;
    @(negedge clk);
    thr_up_i = 15;
    busy_lvl = 0;
    check("R8 ratio after ready", clk_ratio_o, exp_r[2]);
    check("R10 single step", op_idx_o, 2);
    check("R8 vreq cleared", vreq_o, 0);
    wait_cyc(25);
    check("R10 no extra step", op_idx_o, 2);
  endtask

  task automatic t_window_len;
    int t3, t4, t5;
    t3 = 0; t4 = 0; t5 = 0;
    win_len_i = 7; busy_lvl = 1; thr_up_i = 3; vreg_ready_i = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (op_idx_o == 3 && t3 == 0) t3 = cyc;
      if (op_idx_o == 4 && t4 == 0) t4 = cyc;
      if (op_idx_o == 5 && t5 == 0) begin t5 = cyc; break; end
    end
    check("R3 period 3->4", t4 - t3, 7);
    check("R3 period 4->5", t5 - t4, 7);
    wait_cyc(30);
    check("R7 top idx", op_idx_o, 5);
    check("R2 top vcode", vcode_o, exp_v[5]);
    check("R2 top ratio", clk_ratio_o, exp_r[5]);
  endtask

  task automatic t_down_order;
    busy_lvl = 0; thr_up_i = 15; thr_dn_i = 2; vreg_ready_i = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clk_ratio_o != exp_r[5]) break;
    end
    check("R9 ratio first", clk_ratio_o, exp_r[4]);
    check("R9 vcode kept", vcode_o, exp_v[5]);
    check("R9 idx kept", op_idx_o, 5);
    @(negedge clk);
    check("R9 vcode lowered", vcode_o, exp_v[4]);
    check("R9 vreq", vreq_o, 1);
    wait_cyc(2);
    check("R11 down wait", op_idx_o, 5);
    vreg_ready_i = 1;
    @(negedge clk);
    check("R5 step down", op_idx_o, 4);
    wait_idx(0, 100);
    check("R7 reach bottom", op_idx_o, 0);
    check("R2 bottom vcode", vcode_o, exp_v[0]);
    check("R2 bottom ratio", clk_ratio_o, exp_r[0]);
    wait_cyc(25);
    check("R7 stay bottom", op_idx_o, 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; busy_lvl = 0; alt_en = 0;
    win_len_i = 10; thr_up_i = 15; thr_dn_i = 0; vreg_ready_i = 1;
    wait_cyc(3);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_bottom_sat;
    t_hysteresis;
    t_up_order;
    t_window_len;
    t_down_order;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule